// File: doc/BRIEF.md
# Serial Audio Port Receiver

This block is the receive side of a stereo serial audio port in slave mode. A bit clock, a channel-select clock and one data line come from an external master. All three are brought into the block's own free-running master clock domain, and their edges are found there. Data bits are taken on rising bit-clock edges. The block decodes three framing formats that share one shift engine: left-justified, right-justified and I2S. It accepts four word lengths and two bit-clock ratios. Each word is presented as a signed value, aligned to the top of a 24-bit field.

The left and right words of a frame are released together, with a one-cycle strobe. A control write loads the format, word-length and ratio fields and restarts alignment. A phase monitor counts master-clock cycles between rising edges of the channel clock. When one frame period differs from the previous period by more than a set limit, the monitor raises a one-cycle resynchronisation request, and the receiver drops its partial frame and locks onto the next boundary.

Top module: `serial_audio_rx`

## Requirements
- R1: Format code 00 selects left-justified framing. The left word is in the half where the channel clock is high, and its MSB is the first bit sampled after the channel-clock edge.
- R2: Format code 01 selects right-justified framing. The left word is in the channel-clock-high half, and its LSB is the last bit sampled before that half ends.
- R3: Format code 10 selects I2S framing. The left word is in the channel-clock-low half, and its MSB is the second bit sampled in the half.
- R4: Word-length code 00, 01, 10 and 11 selects 16, 18, 20 and 24 bits. Each output has its MSB at bit 23 and zeros below the word. Bits of a half outside the word do not affect the output.
- R5: Ratio bit 1 selects 32 bit clocks per half and ratio bit 0 selects 16. At ratio 0 the word length is 16 bits, whatever the word-length code says.
- R6: `sample_valid` is a one-cycle pulse that follows each completed right word whose left word from the same frame was also received. Both outputs update together on that pulse and hold between pulses, and there is exactly one pulse per frame.
- R7: Format code 11 forces both outputs to zero and suppresses `sample_valid`.
- R8: After reset the port decodes I2S with 18-bit words at 32 bit clocks per half. The outputs, `sample_valid` and `resync_req` are all zero.
- R9: If a channel-clock period, counted in master-clock cycles between rising edges, differs from the previous period by more than DRIFT_LIMIT (10), `resync_req` pulses for one cycle and the receiver realigns. A difference within the limit raises no request.
- R10: A cycle with `cfg_wr` high loads the three control fields and discards any partly received frame. Output resumes only after a full left and right word have been received in the new setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running master clock; all state is clocked by it |
| rst_n | input | 1 | Active-low reset |
| sclk_in | input | 1 | Serial bit clock from the external master |
| lrclk_in | input | 1 | Channel-select clock from the external master |
| sdata_in | input | 1 | Serial audio data |
| cfg_wr | input | 1 | Loads the control fields and restarts alignment |
| cfg_fmt | input | 2 | Framing format code |
| cfg_wlen | input | 2 | Word-length code |
| cfg_rate64 | input | 1 | Bit clocks per half: 1 for 32, 0 for 16 |
| left_out | output | 24 | Left sample, MSB-aligned |
| right_out | output | 24 | Right sample, MSB-aligned |
| sample_valid | output | 1 | One-cycle strobe for a new stereo pair |
| resync_req | output | 1 | One-cycle request raised on channel-clock drift |

## Verification
If the bit history is misaligned, the next strobe carries a word that is scaled by a power of two or offset by junk bits. That shows at the ports within one frame. If a pending-left flag is stuck or cleared at the wrong time, the port skips a strobe or pairs a stale left word with a new right word. Counting strobes and comparing values after every segment exposes that by the end of the segment. If the period monitor holds a wrong reference, it produces a false or missing `resync_req` within one or two channel-clock periods. Stretched frames, both inside and beyond the limit, test both directions.

// File: rtl/sap_pkg.sv
`timescale 1ns/1ps
package sap_pkg;
   localparam int HALF_MAX = 32;
   localparam int HIST_W   = HALF_MAX + 1;

   typedef enum logic [1:0] {
      FMT_LJ  = 2'b00,
      FMT_RJ  = 2'b01,
      FMT_I2S = 2'b10,
      FMT_RSV = 2'b11
   } fmt_e;

   typedef struct packed {
      fmt_e       fmt;
      logic [1:0] wlen;
      logic       rate64;
   } cfg_t;

   localparam cfg_t CFG_RESET = '{fmt: FMT_I2S, wlen: 2'b01, rate64: 1'b1};

   function automatic logic [5:0] word_bits(input cfg_t c);
      if (!c.rate64) return 6'd16;
      case (c.wlen)
         2'b00:   return 6'd16;
         2'b01:   return 6'd18;
         2'b10:   return 6'd20;
         default: return 6'd24;
      endcase
   endfunction

   function automatic logic [5:0] half_bits(input cfg_t c);
      return c.rate64 ? 6'd32 : 6'd16;
   endfunction
endpackage

// File: rtl/sap_sync.sv
`timescale 1ns/1ps
module sap_sync #(
   parameter int STAGES = 2,
   parameter int W      = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("sap_sync: STAGES must be at least 1");
   end

   logic [W-1:0] stage [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stage[g] <= '0;
            else        stage[g] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stage[g] <= '0;
            else        stage[g] <= stage[g-1];
      end
   end

   assign q = stage[STAGES-1];
endmodule

// File: rtl/sap_shifter.sv
`timescale 1ns/1ps
module sap_shifter import sap_pkg::*; #(
   parameter int OUT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             sclk_s,
   input  logic             lrclk_s,
   input  logic             sdata_s,
   input  cfg_t             cfg,
   output logic             cap_left,
   output logic             cap_right,
   output logic [OUT_W-1:0] word
);
   localparam int WIDE_W = HIST_W + OUT_W;

   logic              sclk_d, rise, lr_last, have_lr, seen, boundary, left_lvl;
   logic [HIST_W-1:0] hist, hist_now;
   logic [5:0]        wb, hb, rsh;
   logic [6:0]        lsh;
   logic [WIDE_W-1:0] wide, aligned;

   assign rise     = sclk_s & ~sclk_d;
   assign hist_now = {hist[HIST_W-2:0], sdata_s};
   assign boundary = rise && have_lr && (lrclk_s != lr_last) && !restart;
   assign left_lvl = (cfg.fmt != FMT_I2S);
   assign cap_left  = boundary && seen && (lr_last == left_lvl);
   assign cap_right = boundary && seen && (lr_last != left_lvl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d  <= 1'b0;
         hist    <= '0;
         lr_last <= 1'b0;
         have_lr <= 1'b0;
         seen    <= 1'b0;
      end else begin
         sclk_d <= sclk_s;
         if (restart) begin
            have_lr <= 1'b0;
            seen    <= 1'b0;
         end else if (rise) begin
            hist    <= hist_now;
            lr_last <= lrclk_s;
            have_lr <= 1'b1;
            if (boundary) seen <= 1'b1;
         end
      end
   end

   // hist_now[0] is bit 0 of the new half; hist_now[k] is bit (H-k) of the half just ended
   always_comb begin
      wb = word_bits(cfg);
      hb = half_bits(cfg);
      case (cfg.fmt)
         FMT_LJ:  rsh = hb - wb + 6'd1;
         FMT_RJ:  rsh = 6'd1;
         default: rsh = hb - wb;
      endcase
      lsh     = 7'(OUT_W) - {1'b0, wb};
      wide    = {{OUT_W{1'b0}}, hist_now} >> rsh;
      aligned = wide << lsh;
      word    = aligned[OUT_W-1:0];
   end

   // captures come from distinct bit-clock rises, so never on adjacent cycles
   p_capture_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_left || cap_right) |=> !(cap_left || cap_right));
endmodule

// File: rtl/sap_drift.sv
`timescale 1ns/1ps
module sap_drift #(
   parameter int PERIOD_W    = 12,
   parameter int DRIFT_LIMIT = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic lrclk_s,
   output logic resync
);
   if (DRIFT_LIMIT >= (1 << PERIOD_W)) begin : g_bad_limit
      $error("sap_drift: DRIFT_LIMIT does not fit in PERIOD_W");
   end

   logic                lr_d, lr_rise, have_start, ref_valid;
   logic [PERIOD_W-1:0] cnt, ref_per, diff;

   assign lr_rise = lrclk_s & ~lr_d;
   assign diff    = (cnt > ref_per) ? cnt - ref_per : ref_per - cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lr_d       <= 1'b0;
         cnt        <= '0;
         ref_per    <= '0;
         have_start <= 1'b0;
         ref_valid  <= 1'b0;
         resync     <= 1'b0;
      end else begin
         lr_d   <= lrclk_s;
         resync <= 1'b0;
         if (cnt != '1) cnt <= cnt + 1'b1;
         if (restart) begin
            have_start <= 1'b0;
            ref_valid  <= 1'b0;
         end else if (lr_rise) begin
            cnt        <= PERIOD_W'(1);
            have_start <= 1'b1;
            if (have_start) begin
               if (ref_valid && diff > PERIOD_W'(DRIFT_LIMIT)) begin
                  resync    <= 1'b1;
                  ref_valid <= 1'b0;
               end else begin
                  ref_per   <= cnt;
                  ref_valid <= 1'b1;
               end
            end
         end
      end
   end

   p_resync_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      resync |=> !resync);
endmodule

// File: rtl/serial_audio_rx.sv
`timescale 1ns/1ps
module serial_audio_rx import sap_pkg::*; #(
   parameter int OUT_W       = 24,
   parameter int SYNC_STAGES = 2,
   parameter int DRIFT_LIMIT = 10,
   parameter int PERIOD_W    = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sclk_in,
   input  logic             lrclk_in,
   input  logic             sdata_in,
   input  logic             cfg_wr,
   input  logic [1:0]       cfg_fmt,
   input  logic [1:0]       cfg_wlen,
   input  logic             cfg_rate64,
   output logic [OUT_W-1:0] left_out,
   output logic [OUT_W-1:0] right_out,
   output logic             sample_valid,
   output logic             resync_req
);
   if (OUT_W < 24) begin : g_bad_width
      $error("serial_audio_rx: OUT_W must hold a 24-bit word");
   end

   logic             sclk_s, lrclk_s, sdata_s, restart, cap_left, cap_right, pend;
   logic [OUT_W-1:0] word, pend_val;
   cfg_t             cfg_q;

   sap_sync #(.STAGES(SYNC_STAGES), .W(3)) i_sync (
      .clk(clk), .rst_n(rst_n),
      .d({sclk_in, lrclk_in, sdata_in}),
      .q({sclk_s, lrclk_s, sdata_s}));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      cfg_q <= CFG_RESET;
      else if (cfg_wr) cfg_q <= '{fmt: fmt_e'(cfg_fmt), wlen: cfg_wlen, rate64: cfg_rate64};

   assign restart = cfg_wr | resync_req;

   sap_shifter #(.OUT_W(OUT_W)) i_shift (
      .clk(clk), .rst_n(rst_n), .restart(restart),
      .sclk_s(sclk_s), .lrclk_s(lrclk_s), .sdata_s(sdata_s), .cfg(cfg_q),
      .cap_left(cap_left), .cap_right(cap_right), .word(word));

   sap_drift #(.PERIOD_W(PERIOD_W), .DRIFT_LIMIT(DRIFT_LIMIT)) i_drift (
      .clk(clk), .rst_n(rst_n), .restart(cfg_wr),
      .lrclk_s(lrclk_s), .resync(resync_req));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_out     <= '0;
         right_out    <= '0;
         sample_valid <= 1'b0;
         pend         <= 1'b0;
         pend_val     <= '0;
      end else begin
         sample_valid <= 1'b0;
         if (cfg_q.fmt == FMT_RSV) begin
            left_out  <= '0;
            right_out <= '0;
            pend      <= 1'b0;
         end else if (restart) begin
            pend <= 1'b0;
         end else if (cap_left) begin
            pend_val <= word;
            pend     <= 1'b1;
         end else if (cap_right && pend) begin
            left_out     <= pend_val;
            right_out    <= word;
            sample_valid <= 1'b1;
            pend         <= 1'b0;
         end
      end
   end

   p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid |=> !sample_valid);

   p_hold_between_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!sample_valid && $past(cfg_q.fmt) != FMT_RSV) |-> ($stable(left_out) && $stable(right_out)));

   p_reserved_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q.fmt == FMT_RSV) |=> (left_out == '0 && right_out == '0 && !sample_valid));
endmodule

// File: tb/test_serial_audio_rx.sv
`timescale 1ns/1ps
module test_serial_audio_rx;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic        sclk_in = 1'b0, lrclk_in = 1'b0, sdata_in = 1'b0;
   logic        cfg_wr = 1'b0, cfg_rate64 = 1'b1;
   logic [1:0]  cfg_fmt = 2'b10, cfg_wlen = 2'b01;
   logic [23:0] left_out, right_out;
   logic        sample_valid, resync_req;

   serial_audio_rx i_serial_audio_rx (
      .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .lrclk_in(lrclk_in), .sdata_in(sdata_in),
      .cfg_wr(cfg_wr), .cfg_fmt(cfg_fmt), .cfg_wlen(cfg_wlen), .cfg_rate64(cfg_rate64),
      .left_out(left_out), .right_out(right_out),
      .sample_valid(sample_valid), .resync_req(resync_req));

   always #10 clk = ~clk;

   int          n_chk = 0, n_fail = 0, valid_seen = 0, resync_seen = 0;
   bit          chk_en = 1'b1, done = 1'b0, carry = 1'b0;
   int          cur_fmt = 2, cur_w = 18, cur_h = 32;
   string       seg_tag = "R8";
   logic [23:0] q_l[$], q_r[$];
   logic [23:0] last_l = '0, last_r = '0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [23:0] exp_al(input logic [23:0] v, input int w);
      return 24'(v << (24 - w));
   endfunction

   // monitor: sampled on the falling clock edge
   initial begin
      bit pv = 1'b0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (sample_valid) begin
               valid_seen++;
               last_l = left_out;
               last_r = right_out;
               check(!pv, "R6 strobe lasts one cycle", 32'(pv), 0);
               if (chk_en) begin
                  if (q_l.size() == 0) begin
                     check(0, {seg_tag, " R7 unexpected strobe"}, 32'(left_out), 0);
                  end else begin
                     logic [23:0] el, er;
                     el = q_l.pop_front();
                     er = q_r.pop_front();
                     check(left_out == el, {seg_tag, " left word"}, 32'(left_out), 32'(el));
                     check(right_out == er, {seg_tag, " right word"}, 32'(right_out), 32'(er));
                  end
               end
            end
            if (resync_req) resync_seen++;
            pv = sample_valid;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic send_bit(input logic lvl, input logic b);
      @(negedge clk);
      sclk_in  = 1'b0;
      lrclk_in = lvl;
      sdata_in = b;
      @(negedge clk);
      @(negedge clk);
      sclk_in = 1'b1;
      @(negedge clk);
   endtask

   task automatic send_half(input logic lvl, input logic [23:0] v, input bit has, input int extra);
      for (int p = 0; p < cur_h + extra; p++) begin
         logic b;
         b = 1'($urandom_range(0, 1));
         if (cur_fmt == 2 && p == 0 && cur_w == cur_h) b = carry;
         else if (has) begin
            if (cur_fmt == 0 && p < cur_w) b = v[cur_w-1-p];
            else if (cur_fmt == 1 && p >= cur_h - cur_w && p < cur_h) b = v[cur_h-1-p];
            else if (cur_fmt == 2 && p >= 1 && p <= cur_w && p < cur_h) b = v[cur_w-p];
         end
         send_bit(lvl, b);
      end
      if (cur_fmt == 2 && cur_w == cur_h) carry = has ? v[0] : 1'($urandom_range(0, 1));
   endtask

   function automatic logic left_level();
      return (cur_fmt == 2) ? 1'b0 : 1'b1;
   endfunction

   task automatic send_frame(input logic [23:0] vl, input logic [23:0] vr, input int extra, input bit push);
      if (push) begin
         q_l.push_back(exp_al(vl, cur_w));
         q_r.push_back(exp_al(vr, cur_w));
      end
      send_half(left_level(), vl, 1, 0);
      send_half(~left_level(), vr, 1, extra);
   endtask

   function automatic logic [23:0] rnd_word();
      return 24'($urandom & ((32'd1 << cur_w) - 1));
   endfunction

   task automatic apply_cfg(input int f, input int wl, input bit r64);
      @(negedge clk);
      cfg_fmt    = 2'(f);
      cfg_wlen   = 2'(wl);
      cfg_rate64 = r64;
      cfg_wr     = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
      repeat (2) @(negedge clk);
      cur_fmt = f;
      cur_h   = r64 ? 32 : 16;
      cur_w   = !r64 ? 16 : (wl == 0) ? 16 : (wl == 1) ? 18 : (wl == 2) ? 20 : 24;
   endtask

   task automatic run_seg(input int f, input int wl, input bit r64, input int nfr, input bit do_cfg, input string tag);
      int v0;
      seg_tag = tag;
      if (do_cfg) apply_cfg(f, wl, r64);
      send_half(~left_level(), '0, 0, 0);
      v0 = valid_seen;
      for (int k = 0; k < nfr; k++) send_frame(rnd_word(), rnd_word(), 0, f != 3);
      send_half(left_level(), '0, 0, 0);
      repeat (6) @(negedge clk);
      check(valid_seen - v0 == ((f == 3) ? 0 : nfr), {tag, " R6 strobe count"},
            32'(valid_seen - v0), 32'((f == 3) ? 0 : nfr));
      check(q_l.size() == 0, {tag, " R6 all frames delivered"}, 32'(q_l.size()), 0);
   endtask

   initial begin
      int r0;
      logic [23:0] fl, fr;
      repeat (5) @(negedge clk);
      check(left_out == '0 && right_out == '0, "R8 outputs zero in reset", 32'(left_out | right_out), 0);
      check(!sample_valid && !resync_req, "R8 strobes low in reset", 32'({sample_valid, resync_req}), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(left_out == '0 && !sample_valid, "R8 outputs zero after reset", 32'(left_out), 0);

      // R8: default setting is I2S, 18 bits, 32 bit clocks per half
      run_seg(2, 1, 1, 4, 0, "R8 default I2S 18-bit");

      // R1 R2 R3 R4: every format with every word length at the wide ratio
      for (int f = 0; f < 3; f++)
         for (int wl = 0; wl < 4; wl++)
            run_seg(f, wl, 1, 3, 1, (f == 0) ? "R1 R4 left-justified" :
                                    (f == 1) ? "R2 R4 right-justified" : "R3 R4 I2S");

      // R7: reserved code blanks outputs
      run_seg(3, 3, 1, 2, 1, "R7 reserved");
      check(left_out == '0, "R7 left held zero", 32'(left_out), 0);
      check(right_out == '0, "R7 right held zero", 32'(right_out), 0);

      // R5: narrow ratio forces 16-bit words
      for (int f = 0; f < 3; f++) run_seg(f, 3, 0, 3, 1, "R5 narrow ratio 16-bit");
      run_seg(1, 2, 0, 2, 1, "R5 narrow ratio right-justified");

      // R10: a half-received frame is dropped by a control write
      apply_cfg(0, 2, 1);
      send_half(1'b0, '0, 0, 0);
      send_half(1'b1, rnd_word(), 1, 0);
      r0 = valid_seen;
      run_seg(0, 2, 1, 3, 1, "R10 restart on write");
      check(valid_seen - r0 == 3, "R10 no stale pair", 32'(valid_seen - r0), 3);

      // R9: drift within and beyond the limit
      chk_en = 1'b0;
      apply_cfg(0, 3, 1);
      send_half(1'b0, '0, 0, 0);
      r0 = resync_seen;
      for (int k = 0; k < 3; k++) send_frame(rnd_word(), rnd_word(), 0, 0);
      send_frame(rnd_word(), rnd_word(), 2, 0);
      for (int k = 0; k < 2; k++) send_frame(rnd_word(), rnd_word(), 0, 0);
      check(resync_seen == r0, "R9 no request within limit", 32'(resync_seen - r0), 0);
      send_frame(rnd_word(), rnd_word(), 4, 0);
      for (int k = 0; k < 3; k++) begin
         fl = rnd_word();
         fr = rnd_word();
         send_frame(fl, fr, 0, 0);
      end
      send_half(1'b1, '0, 0, 0);
      repeat (6) @(negedge clk);
      check(resync_seen == r0 + 1, "R9 one request beyond limit", 32'(resync_seen - r0), 1);
      check(last_l == exp_al(fl, 24), "R9 left realigned", 32'(last_l), 32'(exp_al(fl, 24)));
      check(last_r == exp_al(fr, 24), "R9 right realigned", 32'(last_r), 32'(exp_al(fr, 24)));
      chk_en = 1'b1;
      check(resync_seen == 1, "R9 no request in regular traffic", 32'(resync_seen), 1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule